// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block produces the control word that steers every register, the ALU and the memory of a small 8-bit CPU built around one shared bus. Three inputs form a microcode address: the instruction register value, the carry and zero flags, and an internal 3-bit step count. The address indexes a computed control table. The datapath consumes the control word and does nothing else with the sequencer.

Each step is split into ordered time slots of a single clock. In the action slot the datapath acts on the current word; the block marks that slot with an action strobe. In the next slot the step counter advances. In the slot after that, a snapshot register captures the step, the instruction and the flags. One or more settle slots follow before the next action slot. The control word is always decoded from the snapshot and never from the live inputs, so it changes only once per step, one slot after the snapshot edge. Input changes between two snapshots therefore have no effect on it.

Every instruction begins with the same two fetch steps. After that, decoding uses the upper four bits of the instruction. An instruction ends by asserting the step-clear bit, which returns the counter to zero at the next step edge. A halt word freezes the slot sequence, so no further action strobes occur until reset.

Top module: `ucode_seq`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `step_o` is 0, `act_o` is 1 and `ctrl_o` holds the first fetch word (pc_out | mar_load).
- R2: Control word bit positions: 0 pc_out, 1 mar_load, 2 mem_out, 3 ir_load, 4 pc_inc, 5 a_load, 6 a_out, 7 b_load, 8 b_out, 9 alu_out, 10 alu_sub, 11 flag_load, 12 mem_write, 13 pc_load, 14 out_load, 15 a_clr, 16 b_clr, 17 flag_clr, 18 pc_clr, 19 step_clr, 20 halt. The table address is the snapshot of {carry_i, zero_i, ir_i, step}.
- R3: With the default of one settle slot, a step lasts 4 cycles. `act_o` is high in the first cycle of each step only. The step count changes at the end of the second cycle. The snapshot is taken at the end of the third cycle.
- R4: At each step edge the step count increments by one. If the current word has step_clr, the count becomes 0 instead.
- R5: `ctrl_o` changes only in the cycle after a snapshot edge. Changes to `ir_i`, `carry_i` or `zero_i` after a snapshot do not alter `ctrl_o` before the next snapshot.
- R6: For any instruction, step 0 gives pc_out | mar_load and step 1 gives mem_out | ir_load | pc_inc.
- R7: The opcode is `ir_i[7:4]` and `ir_i[3:0]` is ignored. Operand steps are step 2 = pc_out | mar_load and step 3 = mem_out | mar_load | pc_inc. The opcodes using them: 0x1 load A (step 4: mem_out | a_load | step_clr), 0x4 store A (step 4: a_out | mem_write | step_clr), 0x6 jump (step 3 replaced by mem_out | pc_load | step_clr). 0x5 load immediate uses only step 2 of the two, then step 3: mem_out | a_load | pc_inc | step_clr. 0x9 output (step 2: a_out | out_load | step_clr). 0xA clear (step 2: a_clr | b_clr | flag_clr | step_clr).
- R8: Opcodes 0x2 (add) and 0x3 (subtract) use the operand steps, then step 4: mem_out | b_load, then step 5: alu_out | a_load | flag_load | step_clr, with alu_sub added for 0x3.
- R9: Opcode 0x7 branches on carry and 0x8 on zero. At step 3 the word is mem_out | pc_load | step_clr when the flag is 1. When the flag is 0 it is pc_inc | step_clr, which skips the operand.
- R10: Opcode 0x0 and the unassigned opcodes 0xB to 0xE give step_clr alone from step 2 on. Any step past an instruction's last step also gives step_clr alone.
- R11: At most one of pc_out, mem_out, a_out, b_out, alu_out is set in any control word.
- R12: Opcode 0xF gives halt at step 2. From then on `act_o` stays 0 and both `step_o` and `ctrl_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; all slots are cycles of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_i | input | 8 | Instruction register value |
| carry_i | input | 1 | Latched carry flag |
| zero_i | input | 1 | Latched zero flag |
| ctrl_o | output | 21 | Control word decoded from the snapshot |
| step_o | output | 3 | Current step count |
| act_o | output | 1 | High during the action slot of each step |

## Verification
The bench builds the block with its defaults: 8 instruction bits, 3 step bits and one settle slot, which gives a 4-cycle step. Any step k is then reached exactly 4k cycles after reset. That makes every table entry, including steps 4 and 5 of the ALU opcodes and both branch outcomes, reachable with a short count of cycles. The one-slot settle window also makes the snapshot edge easy to find, so the bench can change the instruction between snapshots and see at which edge the word follows.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;

  localparam int CW = 21;
  typedef logic [CW-1:0] ctrl_t;

  // control bit positions
  localparam int B_PC_OUT    = 0;
  localparam int B_MAR_LOAD  = 1;
  localparam int B_MEM_OUT   = 2;
  localparam int B_IR_LOAD   = 3;
  localparam int B_PC_INC    = 4;
  localparam int B_A_LOAD    = 5;
  localparam int B_A_OUT     = 6;
  localparam int B_B_LOAD    = 7;
  localparam int B_B_OUT     = 8;
  localparam int B_ALU_OUT   = 9;
  localparam int B_ALU_SUB   = 10;
  localparam int B_FLAG_LOAD = 11;
  localparam int B_MEM_WRITE = 12;
  localparam int B_PC_LOAD   = 13;
  localparam int B_OUT_LOAD  = 14;
  localparam int B_A_CLR     = 15;
  localparam int B_B_CLR     = 16;
  localparam int B_FLAG_CLR  = 17;
  localparam int B_PC_CLR    = 18;
  localparam int B_STEP_CLR  = 19;
  localparam int B_HALT      = 20;

  localparam ctrl_t M_PC_OUT    = ctrl_t'(1) << B_PC_OUT;
  localparam ctrl_t M_MAR_LOAD  = ctrl_t'(1) << B_MAR_LOAD;
  localparam ctrl_t M_MEM_OUT   = ctrl_t'(1) << B_MEM_OUT;
  localparam ctrl_t M_IR_LOAD   = ctrl_t'(1) << B_IR_LOAD;
  localparam ctrl_t M_PC_INC    = ctrl_t'(1) << B_PC_INC;
  localparam ctrl_t M_A_LOAD    = ctrl_t'(1) << B_A_LOAD;
  localparam ctrl_t M_A_OUT     = ctrl_t'(1) << B_A_OUT;
  localparam ctrl_t M_B_LOAD    = ctrl_t'(1) << B_B_LOAD;
  localparam ctrl_t M_B_OUT     = ctrl_t'(1) << B_B_OUT;
  localparam ctrl_t M_ALU_OUT   = ctrl_t'(1) << B_ALU_OUT;
  localparam ctrl_t M_ALU_SUB   = ctrl_t'(1) << B_ALU_SUB;
  localparam ctrl_t M_FLAG_LOAD = ctrl_t'(1) << B_FLAG_LOAD;
  localparam ctrl_t M_MEM_WRITE = ctrl_t'(1) << B_MEM_WRITE;
  localparam ctrl_t M_PC_LOAD   = ctrl_t'(1) << B_PC_LOAD;
  localparam ctrl_t M_OUT_LOAD  = ctrl_t'(1) << B_OUT_LOAD;
  localparam ctrl_t M_A_CLR     = ctrl_t'(1) << B_A_CLR;
  localparam ctrl_t M_B_CLR     = ctrl_t'(1) << B_B_CLR;
  localparam ctrl_t M_FLAG_CLR  = ctrl_t'(1) << B_FLAG_CLR;
  localparam ctrl_t M_STEP_CLR  = ctrl_t'(1) << B_STEP_CLR;
  localparam ctrl_t M_HALT      = ctrl_t'(1) << B_HALT;

  // bus drivers, at most one per word
  localparam ctrl_t M_DRIVERS = M_PC_OUT | M_MEM_OUT | M_A_OUT | M_B_OUT | M_ALU_OUT;

  // opcodes (upper nibble of the instruction)
  localparam logic [3:0] OP_NOP = 4'h0;
  localparam logic [3:0] OP_LDA = 4'h1;
  localparam logic [3:0] OP_ADD = 4'h2;
  localparam logic [3:0] OP_SUB = 4'h3;
  localparam logic [3:0] OP_STA = 4'h4;
  localparam logic [3:0] OP_LDI = 4'h5;
  localparam logic [3:0] OP_JMP = 4'h6;
  localparam logic [3:0] OP_JC  = 4'h7;
  localparam logic [3:0] OP_JZ  = 4'h8;
  localparam logic [3:0] OP_OUT = 4'h9;
  localparam logic [3:0] OP_CLR = 4'hA;
  localparam logic [3:0] OP_HLT = 4'hF;

endpackage

// File: rtl/useq_phase.sv
module useq_phase #(
  parameter int SETTLE_SLOTS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic act_en,
  output logic step_en,
  output logic snap_en
);

  // at least one settle slot so a halt word is seen before the next action
  localparam int SETTLE_EFF = (SETTLE_SLOTS < 1) ? 1 : SETTLE_SLOTS;
  localparam int SLOTS      = 3 + SETTLE_EFF;
  localparam int PH_W       = $clog2(SLOTS);
  localparam logic [PH_W-1:0] PH_ACT  = PH_W'(0);
  localparam logic [PH_W-1:0] PH_STEP = PH_W'(1);
  localparam logic [PH_W-1:0] PH_SNAP = PH_W'(2);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOTS - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    ph_d = ph_q;
    if (ph_q == PH_LAST) begin
      if (!hold) ph_d = PH_ACT;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_ACT;
    else        ph_q <= ph_d;
  end

  assign act_en  = (ph_q == PH_ACT);
  assign step_en = (ph_q == PH_STEP);
  assign snap_en = (ph_q == PH_SNAP);

endmodule

// File: rtl/useq_step.sv
module useq_step #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  output logic [STEP_W-1:0] step
);

  logic [STEP_W-1:0] step_d;

  always_comb begin
    step_d = step;
    if (en) begin
      if (clr) step_d = '0;
      else     step_d = step + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= '0;
    else        step <= step_d;
  end

endmodule

// File: rtl/useq_snap.sv
module useq_snap #(
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/useq_rom.sv
module useq_rom
  import ucode_seq_pkg::*;
#(
  parameter int IR_W   = 8,
  parameter int STEP_W = 3
) (
  input  logic [IR_W+STEP_W+1:0] addr,
  output ctrl_t                  word
);

  localparam ctrl_t W_FETCH0 = M_PC_OUT | M_MAR_LOAD;
  localparam ctrl_t W_FETCH1 = M_MEM_OUT | M_IR_LOAD | M_PC_INC;
  localparam ctrl_t W_OPND_A = M_PC_OUT | M_MAR_LOAD;
  localparam ctrl_t W_OPND_B = M_MEM_OUT | M_MAR_LOAD | M_PC_INC;

  logic              cy;
  logic              zf;
  logic [3:0]        op;
  logic [STEP_W-1:0] st;

  assign cy = addr[IR_W+STEP_W+1];
  assign zf = addr[IR_W+STEP_W];
  assign op = addr[IR_W+STEP_W-1 -: 4];
  assign st = addr[STEP_W-1:0];

  generate
    if (IR_W > 4) begin : g_low_ir
      logic unused_ir_lo;
      assign unused_ir_lo = ^addr[STEP_W+IR_W-5:STEP_W];
    end
  endgenerate

  always_comb begin
    word = M_STEP_CLR;
    if (st == STEP_W'(0)) begin
      word = W_FETCH0;
    end else if (st == STEP_W'(1)) begin
      word = W_FETCH1;
    end else begin
      case (op)
        OP_LDA: begin
          if      (st == STEP_W'(2)) word = W_OPND_A;
          else if (st == STEP_W'(3)) word = W_OPND_B;
          else if (st == STEP_W'(4)) word = M_MEM_OUT | M_A_LOAD | M_STEP_CLR;
        end
        OP_ADD, OP_SUB: begin
          if      (st == STEP_W'(2)) word = W_OPND_A;
          else if (st == STEP_W'(3)) word = W_OPND_B;
          else if (st == STEP_W'(4)) word = M_MEM_OUT | M_B_LOAD;
          else if (st == STEP_W'(5))
            word = M_ALU_OUT | M_A_LOAD | M_FLAG_LOAD | M_STEP_CLR
                 | ((op == OP_SUB) ? M_ALU_SUB : '0);
        end
        OP_STA: begin
          if      (st == STEP_W'(2)) word = W_OPND_A;
          else if (st == STEP_W'(3)) word = W_OPND_B;
          else if (st == STEP_W'(4)) word = M_A_OUT | M_MEM_WRITE | M_STEP_CLR;
        end
        OP_LDI: begin
          if      (st == STEP_W'(2)) word = W_OPND_A;
          else if (st == STEP_W'(3)) word = M_MEM_OUT | M_A_LOAD | M_PC_INC | M_STEP_CLR;
        end
        OP_JMP, OP_JC, OP_JZ: begin
          if (st == STEP_W'(2)) begin
            word = W_OPND_A;
          end else if (st == STEP_W'(3)) begin
            if ((op == OP_JMP) || (op == OP_JC && cy) || (op == OP_JZ && zf))
              word = M_MEM_OUT | M_PC_LOAD | M_STEP_CLR;
            else
              word = M_PC_INC | M_STEP_CLR;
          end
        end
        OP_OUT: begin
          if (st == STEP_W'(2)) word = M_A_OUT | M_OUT_LOAD | M_STEP_CLR;
        end
        OP_CLR: begin
          if (st == STEP_W'(2)) word = M_A_CLR | M_B_CLR | M_FLAG_CLR | M_STEP_CLR;
        end
        OP_HLT: begin
          word = M_HALT;
        end
        default: word = M_STEP_CLR;
      endcase
    end
  end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_seq_pkg::*;
#(
  parameter int IR_W         = 8,
  parameter int STEP_W       = 3,
  parameter int SETTLE_SLOTS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic [CW-1:0]     ctrl_o,
  output logic [STEP_W-1:0] step_o,
  output logic              act_o
);

  localparam int ADDR_W = 2 + IR_W + STEP_W;

  logic              act_en;
  logic              step_en;
  logic              snap_en;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] addr_live;
  logic [ADDR_W-1:0] addr_snap;
  ctrl_t             word;

  useq_phase #(.SETTLE_SLOTS(SETTLE_SLOTS)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (word[B_HALT]),
    .act_en  (act_en),
    .step_en (step_en),
    .snap_en (snap_en)
  );

  useq_step #(.STEP_W(STEP_W)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step_en),
    .clr   (word[B_STEP_CLR]),
    .step  (step)
  );

  assign addr_live = {carry_i, zero_i, ir_i, step};

  useq_snap #(.WIDTH(ADDR_W)) u_snap (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (snap_en),
    .d     (addr_live),
    .q     (addr_snap)
  );

  useq_rom #(.IR_W(IR_W), .STEP_W(STEP_W)) u_rom (
    .addr (addr_snap),
    .word (word)
  );

  assign ctrl_o = word;
  assign step_o = step;
  assign act_o  = act_en;

endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk
  import ucode_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     ctrl_o,
  input logic [STEP_W-1:0] step_o,
  input logic              act_o,
  input logic              step_en,
  input logic              snap_en
);

  // R11
  p_one_driver_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctrl_o & M_DRIVERS) <= 1);

  // R5
  p_word_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(snap_en) |-> $stable(ctrl_o));

  // R4
  p_step_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step_en) |-> $stable(step_o));

  p_step_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_en) && $past(ctrl_o[B_STEP_CLR])) |-> (step_o == '0));

  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_en) && !$past(ctrl_o[B_STEP_CLR])) |-> (step_o == STEP_W'($past(step_o) + 1'b1)));

  // R3
  p_act_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |=> !act_o);

  // R12
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[B_HALT] |-> !act_o);

endmodule

bind ucode_seq ucode_seq_chk #(.STEP_W(STEP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl_o  (ctrl_o),
  .step_o  (step_o),
  .act_o   (act_o),
  .step_en (step_en),
  .snap_en (snap_en)
);

// File: tb/ucode_seq_tb.sv
`timescale 1ns/1ps
module ucode_seq_tb;

  // bit map from R2
  localparam logic [20:0] PCO = 21'd1 << 0;
  localparam logic [20:0] MAR = 21'd1 << 1;
  localparam logic [20:0] MEO = 21'd1 << 2;
  localparam logic [20:0] IRL = 21'd1 << 3;
  localparam logic [20:0] PCI = 21'd1 << 4;
  localparam logic [20:0] AL  = 21'd1 << 5;
  localparam logic [20:0] AO  = 21'd1 << 6;
  localparam logic [20:0] BL  = 21'd1 << 7;
  localparam logic [20:0] ALO = 21'd1 << 9;
  localparam logic [20:0] SBT = 21'd1 << 10;
  localparam logic [20:0] FL  = 21'd1 << 11;
  localparam logic [20:0] MW  = 21'd1 << 12;
  localparam logic [20:0] PCL = 21'd1 << 13;
  localparam logic [20:0] OL  = 21'd1 << 14;
  localparam logic [20:0] ACL = 21'd1 << 15;
  localparam logic [20:0] BCL = 21'd1 << 16;
  localparam logic [20:0] FCL = 21'd1 << 17;
  localparam logic [20:0] SCL = 21'd1 << 19;
  localparam logic [20:0] HLT = 21'd1 << 20;
  localparam logic [20:0] DRV = PCO | MEO | AO | (21'd1 << 8) | ALO;

  typedef struct packed {
    logic [7:0]  ir;
    logic        c;
    logic        z;
    logic [2:0]  step;
    logic [20:0] word;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 1'b0, 1'b0, 3'd0, PCO | MAR,             4'd6},  // R6
    '{8'h00, 1'b0, 1'b0, 3'd1, MEO | IRL | PCI,       4'd6},  // R6
    '{8'h00, 1'b0, 1'b0, 3'd2, SCL,                   4'd10}, // R10
    '{8'h10, 1'b0, 1'b0, 3'd2, PCO | MAR,             4'd7},  // R7
    '{8'h10, 1'b0, 1'b0, 3'd3, MEO | MAR | PCI,       4'd7},  // R7
    '{8'h10, 1'b0, 1'b0, 3'd4, MEO | AL | SCL,        4'd7},  // R7
    '{8'h20, 1'b1, 1'b1, 3'd4, MEO | BL,              4'd8},  // R8
    '{8'h20, 1'b0, 1'b0, 3'd5, ALO | AL | FL | SCL,   4'd8},  // R8
    '{8'h35, 1'b0, 1'b0, 3'd5, ALO | SBT | AL | FL | SCL, 4'd8}, // R8
    '{8'h40, 1'b0, 1'b0, 3'd4, AO | MW | SCL,         4'd7},  // R7
    '{8'h50, 1'b0, 1'b0, 3'd3, MEO | AL | PCI | SCL,  4'd7},  // R7
    '{8'h60, 1'b0, 1'b0, 3'd3, MEO | PCL | SCL,       4'd7},  // R7
    '{8'h70, 1'b1, 1'b0, 3'd3, MEO | PCL | SCL,       4'd9},  // R9
    '{8'h70, 1'b0, 1'b1, 3'd3, PCI | SCL,             4'd9},  // R9
    '{8'h80, 1'b0, 1'b1, 3'd3, MEO | PCL | SCL,       4'd9},  // R9
    '{8'h80, 1'b1, 1'b0, 3'd3, PCI | SCL,             4'd9},  // R9
    '{8'h90, 1'b0, 1'b0, 3'd2, AO | OL | SCL,         4'd7},  // R7
    '{8'hA0, 1'b0, 1'b0, 3'd2, ACL | BCL | FCL | SCL, 4'd7},  // R7
    '{8'h1F, 1'b1, 1'b0, 3'd4, MEO | AL | SCL,        4'd7},  // R7 low nibble ignored
    '{8'hB0, 1'b0, 1'b0, 3'd2, SCL,                   4'd10}  // R10
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  ir_i;
  logic        carry_i;
  logic        zero_i;
  logic [20:0] ctrl_o;
  logic [2:0]  step_o;
  logic        act_o;

  int checks;
  int errors;

  ucode_seq u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ir_i    (ir_i),
    .carry_i (carry_i),
    .zero_i  (zero_i),
    .ctrl_o  (ctrl_o),
    .step_o  (step_o),
    .act_o   (act_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic start(input logic [7:0] ir, input logic c, input logic z);
    rst_n   = 1'b0;
    ir_i    = ir;
    carry_i = c;
    zero_i  = z;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0; ir_i = '0; carry_i = 1'b0; zero_i = 1'b0;

    // R1 reset state, held and just released
    @(negedge clk);
    chk("R1 step in reset", 32'(step_o), 32'd0);
    chk("R1 word in reset", 32'(ctrl_o), 32'(PCO | MAR));
    start(8'h00, 1'b0, 1'b0);
    chk("R1 act after release", 32'(act_o), 32'd1);
    chk("R1 word after release", 32'(ctrl_o), 32'(PCO | MAR));

    // R3 slot order, R5 word follows snapshot only
    @(negedge clk); // after edge 1
    chk("R3 act low slot1", 32'(act_o), 32'd0);
    chk("R3 step before step edge", 32'(step_o), 32'd0);
    @(negedge clk); // after edge 2
    chk("R3 step after step edge", 32'(step_o), 32'd1);
    chk("R5 word before snapshot", 32'(ctrl_o), 32'(PCO | MAR));
    @(negedge clk); // after edge 3
    chk("R5 word after snapshot", 32'(ctrl_o), 32'(MEO | IRL | PCI));
    chk("R3 act low settle", 32'(act_o), 32'd0);
    @(negedge clk); // after edge 4
    chk("R3 act at next step", 32'(act_o), 32'd1);

    // R3 one action strobe per 4 cycles
    begin
      int acts;
      start(8'h00, 1'b0, 1'b0);
      acts = 0;
      for (int i = 0; i < 16; i++) begin
        if (act_o) acts++;
        @(negedge clk);
      end
      chk("R3 strobes in 16 cycles", 32'(acts), 32'd4);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      start(VECS[i].ir, VECS[i].c, VECS[i].z);
      repeat (4 * int'(VECS[i].step)) @(negedge clk);
      chk($sformatf("R%0d op %h step %0d", VECS[i].req, VECS[i].ir, VECS[i].step),
          32'(ctrl_o), 32'(VECS[i].word));
      chk($sformatf("R4 step count op %h", VECS[i].ir), 32'(step_o), 32'(VECS[i].step));
      chk("R11 single driver", 32'($countones(ctrl_o & DRV) > 1), 32'd0);
    end

    // R4 step clear wraps to fetch
    start(8'h00, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R4 cleared at step edge", 32'(step_o), 32'd0);
    repeat (2) @(negedge clk);
    chk("R4 back to fetch", 32'(ctrl_o), 32'(PCO | MAR));

    // R5 instruction change between snapshots
    start(8'h10, 1'b0, 1'b0);
    repeat (12) @(negedge clk);
    ir_i = 8'h50;
    carry_i = 1'b1;
    @(negedge clk);
    chk("R5 held after action edge", 32'(ctrl_o), 32'(MEO | MAR | PCI));
    @(negedge clk);
    chk("R5 held after step edge", 32'(ctrl_o), 32'(MEO | MAR | PCI));
    chk("R4 step advanced", 32'(step_o), 32'd4);
    @(negedge clk);
    chk("R10 past last step", 32'(ctrl_o), 32'(SCL));

    // R12 halt freezes
    begin
      int acts;
      start(8'hF0, 1'b0, 1'b0);
      repeat (8) @(negedge clk);
      chk("R12 halt word", 32'(ctrl_o), 32'(HLT));
      acts = 0;
      for (int i = 0; i < 40; i++) begin
        if (act_o) acts++;
        @(negedge clk);
      end
      chk("R12 no strobes", 32'(acts), 32'd0);
      chk("R12 step held", 32'(step_o), 32'd2);
      chk("R12 word held", 32'(ctrl_o), 32'(HLT));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule